// File: doc/BRIEF.md
# Embedded-sync video timing decoder

This block takes a 16-bit YCbCr 4:2:2 stream in which synchronisation travels inside the data, with luma on one byte and chroma on the other. It searches the stream for four-word timing reference codes. From each valid code it reads the vertical-blanking flag and the end/start-of-active flag. It then rebuilds separate data-enable, horizontal sync and vertical sync signals, and delays the pixel data by a fixed amount so that each sync signal lines up with the words it describes.

A status word that follows a well-formed preamble but has broken protection bits raises a one-cycle error flag. Such a code is otherwise ignored. Beside the sync outputs, the block measures the active width, active height and clocks per line of the incoming raster. It latches those three values at every frame boundary so that a controller can read them. The hsync pulse position and width and the vsync length in lines are set through inputs.

Top module: `esd_decoder`

## Requirements
- R1: While reset is held, `vid_out` is the blanking filler 0x8010, the signals `de`, `hs`, `vs` and `code_err` are low, and all three measurement outputs are zero.
- R2: `vid_out` repeats `vid_in` delayed by exactly four clocks: the word sampled at clock edge k is on `vid_out` after edge k+3.
- R3: `de` is high exactly for the output words that come after an SAV status word with V=0 and before the first 0xFFFF word of the next valid EAV preamble. Blanking filler between codes never raises `de`.
- R4: A timing code is the sequence 0xFFFF, 0x0000, 0x0000, S, with the same status byte S on both bytes. In S, bit 7 is always 1, bit 6 is F, bit 5 is V (1 = vertical blanking) and bit 4 is H (1 = EAV, 0 = SAV). The valid values for F=0 are 0xAB and 0x80 for SAV, and 0xB6 and 0x9D for EAV.
- R5: When a preamble is followed by a status word whose two bytes differ, whose bit 7 is clear, or whose bits 3..0 differ from {V^H, F^H, F^V, F^V^H}, `code_err` is high for exactly the one cycle in which `vid_out` shows that preamble's 0xFFFF word.
- R6: A code rejected under R5 does not change `de`, `hs`, `vs` or any measurement.
- R7: `hs` is high for `hs_width` clocks, starting `hs_delay` clocks after the cycle in which `vid_out` shows the 0xFFFF word of a valid EAV. A delay of 0 makes `hs` start on that word. `hs` stays low until the first valid EAV has been seen.
- R8: `vs` rises on the output word that is the 0xFFFF of a valid SAV with V=1, when the previous valid SAV had V=0 (or there was none). `vs` falls at the `vs_lines`-th valid SAV after that point; a value of 0 acts as 1.
- R9: At each rise of `vs`, three values are latched. `act_width` takes the active word count of the last active line, measured from its SAV to its EAV. `act_height` takes the number of valid V=0 SAVs since the previous rise. `line_total` takes the clock distance between the two most recent valid EAVs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_in | input | 16 | Stream with embedded codes, chroma in the upper byte |
| hs_delay | input | 12 | Clocks from the first EAV word to the start of hsync |
| hs_width | input | 12 | Width of the hsync pulse in clocks |
| vs_lines | input | 12 | Length of vsync in lines |
| vid_out | output | 16 | Stream delayed by four clocks |
| de | output | 1 | Active-pixel enable aligned to vid_out |
| hs | output | 1 | Regenerated horizontal sync |
| vs | output | 1 | Regenerated vertical sync |
| code_err | output | 1 | Pulse on a malformed status word |
| act_width | output | 12 | Latched active words per line |
| act_height | output | 12 | Latched active lines per frame |
| line_total | output | 12 | Latched clocks per line |

## Verification
The frame boundary raises `vs` and also makes the measurement block capture its values and restart the line count. Both happen on the same clock edge, triggered by the SAV that changes the vertical flag from clear to set. The bench sends whole reduced frames followed by one extra blanking line so that this edge occurs. It then checks that `act_height` equals the number of active lines sent, with no off-by-one from the restart. It also checks that `vs` rises on the output word holding that SAV's 0xFFFF. A second frame corrupts one EAV and one SAV inside the active area, to confirm that the boundary logic skips rejected codes.

// File: rtl/esd_pkg.sv
package esd_pkg;
  // depth of the data delay: three preamble words plus the status word
  localparam int PIPE = 4;

  typedef struct packed {
    logic sav;     // valid start-of-active code
    logic eav;     // valid end-of-active code
    logic vblank;  // V flag of the status word
    logic bad;     // preamble followed by an illegal status word
  } trs_ev_t;

  function automatic logic [3:0] guard_bits(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
endpackage

// File: rtl/esd_trs_find.sv
module esd_trs_find
  import esd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output trs_ev_t       ev
);
  localparam int HB = DW / 2;
  localparam logic [DW-1:0] FILL = {HB'(8'h80), HB'(8'h10)};

  logic [DW-1:0] dly [PIPE];

  // delay line: stage 0 newest
  always_ff @(posedge clk) begin
    if (rst) dly[0] <= FILL;
    else     dly[0] <= din;
  end

  for (genvar g = 1; g < PIPE; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) dly[g] <= FILL;
      else     dly[g] <= dly[g-1];
    end
  end

  assign dout = dly[PIPE-1];

  logic          pre_seen;
  logic [HB-1:0] st;
  logic          st_ok;

  always_comb begin
    pre_seen = (dly[2] == '1) && (dly[1] == '0) && (dly[0] == '0);
    st       = din[HB-1:0];
    st_ok    = (din[DW-1:HB] == st) && st[7] &&
               (st[3:0] == guard_bits(st[6], st[5], st[4]));
    ev.sav    = pre_seen && st_ok && !st[4];
    ev.eav    = pre_seen && st_ok && st[4];
    ev.vblank = st[5];
    ev.bad    = pre_seen && !st_ok;
  end
endmodule

// File: rtl/esd_sync_gen.sv
module esd_sync_gen
  import esd_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  trs_ev_t       ev,
  input  logic [CW-1:0] hs_delay,
  input  logic [CW-1:0] hs_width,
  input  logic [CW-1:0] vs_lines,
  output logic          de,
  output logic          hs,
  output logic          vs,
  output logic          code_err,
  output logic          frame_tick
);
  logic [PIPE-1:0] sav_sr;
  logic [CW-1:0]   pcnt, nxt, vcnt;
  logic            seen, prev_v;

  assign frame_tick = ev.sav && ev.vblank && !prev_v;

  always_comb nxt = ev.eav ? '0 : ((&pcnt) ? pcnt : pcnt + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sav_sr   <= '0;
      de       <= 1'b0;
      pcnt     <= '0;
      seen     <= 1'b0;
      hs       <= 1'b0;
      prev_v   <= 1'b0;
      vcnt     <= '0;
      vs       <= 1'b0;
      code_err <= 1'b0;
    end else begin
      sav_sr   <= {sav_sr[PIPE-2:0], ev.sav & ~ev.vblank};
      code_err <= ev.bad;
      // data-enable: cleared when the EAV's first word reaches the output
      if (ev.eav)                de <= 1'b0;
      else if (sav_sr[PIPE-1])   de <= 1'b1;
      // horizontal sync counted from the EAV's first word
      pcnt <= nxt;
      if (ev.eav) seen <= 1'b1;
      hs <= (seen || ev.eav) && (nxt >= hs_delay) && ((nxt - hs_delay) < hs_width);
      // vertical sync on valid SAV codes only
      if (ev.sav) begin
        prev_v <= ev.vblank;
        if (frame_tick) begin
          vs   <= 1'b1;
          vcnt <= CW'(1);
        end else if (vs) begin
          if (vcnt >= vs_lines) vs <= 1'b0;
          else                  vcnt <= vcnt + 1'b1;
        end
      end
    end
  end

  p_de_clear_on_eav_r3: assert property (@(posedge clk) disable iff (rst)
    ev.eav |=> !de);
  p_bad_keeps_vs_r6: assert property (@(posedge clk) disable iff (rst)
    ev.bad |=> $stable(vs));
  p_vs_rise_from_sav_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(vs) |-> $past(ev.sav && ev.vblank));
  p_hs_off_zero_width_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(hs_width) == '0) |-> !hs);
endmodule

// File: rtl/esd_meter.sv
module esd_meter
  import esd_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  trs_ev_t       ev,
  input  logic          frame_tick,
  output logic [CW-1:0] meas_w,
  output logic [CW-1:0] meas_h,
  output logic [CW-1:0] meas_t
);
  logic [CW-1:0] scnt, lcnt, last_w, last_t, hcnt;
  logic          line_act, eav_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      scnt <= '0; lcnt <= '0; last_w <= '0; last_t <= '0; hcnt <= '0;
      line_act <= 1'b0; eav_seen <= 1'b0;
      meas_w <= '0; meas_h <= '0; meas_t <= '0;
    end else begin
      scnt <= ev.sav ? '0 : ((&scnt) ? scnt : scnt + 1'b1);
      lcnt <= ev.eav ? '0 : ((&lcnt) ? lcnt : lcnt + 1'b1);
      if (ev.eav) begin
        eav_seen <= 1'b1;
        line_act <= 1'b0;
        if (eav_seen) last_t <= lcnt + 1'b1;
        if (line_act) last_w <= scnt - CW'(PIPE - 1);
      end
      if (ev.sav) begin
        line_act <= !ev.vblank;
        if (!ev.vblank) hcnt <= hcnt + 1'b1;
      end
      if (frame_tick) begin
        meas_w <= last_w;
        meas_h <= hcnt;
        meas_t <= last_t;
        hcnt   <= '0;
      end
    end
  end

  p_meas_hold_on_bad_r6: assert property (@(posedge clk) disable iff (rst)
    ev.bad |=> ($stable(meas_w) && $stable(meas_h) && $stable(meas_t)));
endmodule

// File: rtl/esd_decoder.sv
module esd_decoder
  import esd_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] vid_in,
  input  logic [CW-1:0] hs_delay,
  input  logic [CW-1:0] hs_width,
  input  logic [CW-1:0] vs_lines,
  output logic [DW-1:0] vid_out,
  output logic          de,
  output logic          hs,
  output logic          vs,
  output logic          code_err,
  output logic [CW-1:0] act_width,
  output logic [CW-1:0] act_height,
  output logic [CW-1:0] line_total
);
  trs_ev_t ev;
  logic    frame_tick;

  esd_trs_find #(.DW(DW)) i_find (
    .clk(clk), .rst(rst), .din(vid_in), .dout(vid_out), .ev(ev)
  );

  esd_sync_gen #(.CW(CW)) i_sync (
    .clk(clk), .rst(rst), .ev(ev),
    .hs_delay(hs_delay), .hs_width(hs_width), .vs_lines(vs_lines),
    .de(de), .hs(hs), .vs(vs), .code_err(code_err), .frame_tick(frame_tick)
  );

  esd_meter #(.CW(CW)) i_meter (
    .clk(clk), .rst(rst), .ev(ev), .frame_tick(frame_tick),
    .meas_w(act_width), .meas_h(act_height), .meas_t(line_total)
  );

  // the error pulse must coincide with the rejected preamble on the data path
  p_err_with_ff_r5: assert property (@(posedge clk) disable iff (rst)
    code_err |-> (vid_out == '1));
endmodule

// File: tb/test_esd_decoder.sv
module test_esd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic [DW-1:0] vid_in;
  logic [CW-1:0] hs_delay, hs_width, vs_lines;
  logic [DW-1:0] vid_out;
  logic          de, hs, vs, code_err;
  logic [CW-1:0] act_width, act_height, line_total;

  always #(CLK_PERIOD/2) clk = ~clk;

  esd_decoder #(.DW(DW), .CW(CW)) i_esd_decoder (
    .clk(clk), .rst(rst), .vid_in(vid_in),
    .hs_delay(hs_delay), .hs_width(hs_width), .vs_lines(vs_lines),
    .vid_out(vid_out), .de(de), .hs(hs), .vs(vs), .code_err(code_err),
    .act_width(act_width), .act_height(act_height), .line_total(line_total)
  );

  typedef struct packed {
    logic [31:0]   due;
    logic [DW-1:0] data;
    logic          de, hs, vs, err;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int  tick = 0, checks = 0, fails = 0;
  bit  finished = 0;

  // reference model state
  int n = 0, hpos = 0, de_on_at = -1, vcnt = 0, last_eav = 0, sav_idx = 0;
  int lw = 0, lt = 0, hcnt = 0, mw = 0, mh = 0, mt = 0;
  int cfg_d = 0, cfg_w = 0, cfg_l = 0;
  bit hseen = 0, m_de = 0, m_vs = 0, prev_v = 0, act = 0, eav_seen = 0;

  task automatic chk(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // monitor: compares each due item shortly after the edge
  always @(posedge clk) begin
    #2;
    tick++;
    if (q.size() > 0 && q[0].due == tick) begin
      cur = q.pop_front();
      chk(vid_out == cur.data, "R2 delayed data", int'(vid_out), int'(cur.data));
      chk(de == cur.de, "R3 data enable", int'(de), int'(cur.de));
      chk(hs == cur.hs, "R7 hsync", int'(hs), int'(cur.hs));
      chk(vs == cur.vs, "R8 vsync (R4 flag decode)", int'(vs), int'(cur.vs));
      chk(code_err == cur.err, "R5 code error", int'(code_err), int'(cur.err));
    end
  end

  // driver: kind 0 plain, 1 valid EAV first word, 2 valid SAV first word, 3 rejected
  task automatic emit(input logic [DW-1:0] w, input int kind, input bit v);
    exp_t e;
    bit   h;
    @(negedge clk);
    if (n == de_on_at) begin m_de = 1; de_on_at = -1; end
    case (kind)
      1: begin
        m_de = 0; hpos = 0; hseen = 1;
        if (eav_seen) lt = n - last_eav;
        eav_seen = 1; last_eav = n;
        if (act) lw = n - sav_idx - 1;
        act = 0;
      end
      2: begin
        if (v && !prev_v) begin
          m_vs = 1; vcnt = 1; mw = lw; mh = hcnt; mt = lt; hcnt = 0;
        end else if (m_vs) begin
          if (vcnt >= cfg_l) m_vs = 0;
          else vcnt++;
        end
        prev_v = v;
        act = !v;
        sav_idx = n + 3;
        if (!v) begin hcnt++; de_on_at = n + 4; end
      end
      default: ;
    endcase
    h = hseen && (hpos >= cfg_d) && (hpos < cfg_d + cfg_w);
    hpos++;
    e.due = 32'(tick + 4); e.data = w; e.de = m_de; e.hs = h; e.vs = m_vs; e.err = (kind == 3);
    q.push_back(e);
    vid_in = w;
    n++;
  endtask

  task automatic send_line(input bit v, input int w, input int b, input bit bad_eav, input bit bad_sav);
    logic [7:0] st;
    st = v ? 8'hB6 : 8'h9D;
    if (bad_eav) st = st ^ 8'h01;
    emit(16'hFFFF, bad_eav ? 3 : 1, v);
    emit(16'h0000, 0, 0);
    emit(16'h0000, 0, 0);
    emit({st, st}, 0, 0);
    for (int i = 0; i < b; i++) emit(16'h8010, 0, 0);
    st = v ? 8'hAB : 8'h80;
    emit(16'hFFFF, bad_sav ? 3 : 2, v);
    emit(16'h0000, 0, 0);
    emit(16'h0000, 0, 0);
    emit(bad_sav ? {st, st ^ 8'h02} : {st, st}, 0, 0);
    for (int i = 0; i < w; i++)
      emit(v ? 16'h8010 : {8'h40 + 8'(i), 8'h20 + 8'(i)}, 0, 0);
  endtask

  task automatic send_frame(input int nv, input int na, input int w, input int b,
                            input int bad_eav_at, input int bad_sav_at);
    for (int i = 0; i < nv; i++) send_line(1'b1, w, b, 1'b0, 1'b0);
    for (int i = 0; i < na; i++) send_line(1'b0, w, b, i == bad_eav_at, i == bad_sav_at);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) emit(16'h8010, 0, 0);
  endtask

  task automatic set_cfg(input int d, input int w, input int l);
    cfg_d = d; cfg_w = w; cfg_l = l;
    hs_delay = CW'(d); hs_width = CW'(w); vs_lines = CW'(l);
  endtask

  task automatic check_meas(input string tag, input int ew, input int eh, input int et);
    chk(act_width == CW'(mw), {tag, " width vs model"}, int'(act_width), mw);
    chk(act_height == CW'(mh), {tag, " height vs model"}, int'(act_height), mh);
    chk(line_total == CW'(mt), {tag, " total vs model"}, int'(line_total), mt);
    chk(act_width == CW'(ew), {tag, " programmed width"}, int'(act_width), ew);
    chk(act_height == CW'(eh), {tag, " programmed height"}, int'(act_height), eh);
    chk(line_total == CW'(et), {tag, " programmed total"}, int'(line_total), et);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    vid_in = 16'h8010;
    set_cfg(3, 5, 2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(vid_out == 16'h8010, "R1 reset data", int'(vid_out), 32'h8010);
    chk({de, hs, vs, code_err} == 4'b0, "R1 reset sync", int'({de, hs, vs, code_err}), 0);
    chk(act_width == '0 && act_height == '0 && line_total == '0, "R1 reset measures",
        int'(act_width) + int'(act_height) + int'(line_total), 0);
    rst = 1'b0;

    idle(6);
    // clean frames, 16 active words, 36 clocks per line, 5 active lines
    send_frame(3, 5, 16, 12, -1, -1);
    send_frame(3, 5, 16, 12, -1, -1);
    send_line(1'b1, 16, 12, 1'b0, 1'b0);
    idle(4);
    check_meas("R9 clean frame", 16, 5, 36);

    // corrupted EAV on active line 1 and corrupted SAV on active line 3
    send_frame(2, 5, 16, 12, 1, 3);
    send_line(1'b1, 16, 12, 1'b0, 1'b0);
    idle(4);
    check_meas("R6 rejected codes", 16, 4, 36);

    // second raster shape, hsync at the EAV word itself, single-line vsync
    idle(8);
    set_cfg(0, 1, 0);
    idle(8);
    send_frame(2, 4, 10, 20, -1, -1);
    send_line(1'b1, 10, 20, 1'b0, 1'b0);
    idle(4);
    check_meas("R9 second raster", 10, 4, 38);
    send_frame(1, 4, 10, 20, -1, -1);
    send_line(1'b1, 10, 20, 1'b0, 1'b0);
    idle(12);

    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R2 all words observed", q.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule